// File: doc/BRIEF.md
# Interrupt Pin Request and Acknowledge Logic

This block keeps the pending-request state of a bank of interrupt input pins and decides, one event per clock, whether a pin should launch a delivery. It accepts three kinds of event. A pin level-change event carries a pin index and a level. An end-of-interrupt notification carries a vector number. A rewrite strobe tells the block that a pin's routing entry was just written. The per-pin configuration (mask, polarity, trigger mode and vector) is held elsewhere and is read on flat input vectors.

Edge-triggered and level-triggered pins share one request register. Level pins also keep an in-service flag, called the remote bit here. While that flag is set, the pin cannot be delivered again. The flag is cleared by an end-of-interrupt whose vector maps back to the pin through a lowest-index search of the vector table, or by a rewrite that asks for it to be cleared. A delivery is reported as a one-cycle pulse with the pin index. Choosing the destination is left to a downstream block.

Top module: `irq_req_ack`

## Requirements
- R1: After reset, `req_bits` and `remote_bits` are all zero and `dlv_valid` is low.
- R2: The pin event level is XORed with `cfg_polarity[p]` (1 = active low). A resulting level of 0 clears `req_bits[p]` and gives no delivery.
- R3: A resulting level of 1 sets `req_bits[p]`. Service is then started if the pin is edge mode (`cfg_level_trig[p]`=0) and its request bit was clear, or if its remote bit is clear.
- R4: Service on an unmasked pin (`cfg_mask[p]`=0) raises `dlv_valid` for exactly the next cycle with `dlv_pin`=p. For a level-mode pin it also sets `remote_bits[p]`. A masked pin is never delivered.
- R5: Service on an edge-mode pin clears `req_bits[p]`, whether or not the pin is masked.
- R6: An end-of-interrupt selects the lowest pin p whose vector (`cfg_vector[p*VEC_W +: VEC_W]`) equals `eoi_vector`. It clears `remote_bits[p]` and, if p is unmasked with `req_bits[p]` set, delivers p without setting the remote bit again. With no match, it changes nothing.
- R7: A pin event or a rewrite strobe whose index is not below NUM_PINS changes nothing.
- R8: A rewrite strobe on pin p clears `remote_bits[p]` when `rewr_clr_remote` is 1. If `req_bits[p]` is set, it then services p as in R4 and R5.
- R9: Only one event is acted on per cycle, taken in the order end-of-interrupt, then rewrite strobe, then pin event. The lower-ranked events offered in the same cycle have no effect.
- R10: A level pin whose remote bit is set and whose request bit is already set is not delivered again when its level is reasserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_evt_valid | input | 1 | Pin level-change event strobe |
| pin_evt_idx | input | IDX_W | Pin index of the event |
| pin_evt_level | input | 1 | Raw level of the pin |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | VEC_W | Vector being acknowledged |
| rewr_valid | input | 1 | Routing-entry rewrite strobe |
| rewr_idx | input | IDX_W | Pin whose entry was rewritten |
| rewr_clr_remote | input | 1 | Clear the remote bit with this rewrite |
| cfg_mask | input | NUM_PINS | Per-pin mask, 1 = masked |
| cfg_polarity | input | NUM_PINS | Per-pin polarity, 1 = active low |
| cfg_level_trig | input | NUM_PINS | Per-pin trigger mode, 1 = level, 0 = edge |
| cfg_vector | input | NUM_PINS*VEC_W | Per-pin vectors, pin p at bits p*VEC_W +: VEC_W |
| req_bits | output | NUM_PINS | Request register |
| remote_bits | output | NUM_PINS | Remote (in-service) bits |
| dlv_valid | output | 1 | One-cycle delivery pulse |
| dlv_pin | output | IDX_W | Pin being delivered |

## Verification
The bench builds the block with NUM_PINS=6 and VEC_W=8. With six pins, the 3-bit index can name pins 6 and 7, so the out-of-range events of R7 can be driven directly, and a small table is enough to give two pins the same vector for the lowest-index search of R6. A directed phase covers each trigger, polarity and mask combination. A random phase then offers every mix of simultaneous events against a behavioural model to test the ordering of R9.

// File: rtl/irq_req_pkg.sv
package irq_req_pkg;
  // Event chosen for the current cycle
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_EOI  = 2'd1,
    EV_REWR = 2'd2,
    EV_PIN  = 2'd3
  } ev_kind_e;
endpackage

// File: rtl/irq_vec_search.sv
module irq_vec_search #(
  parameter int NUM_PINS = 24,
  parameter int VEC_W    = 8,
  parameter int IDX_W    = 5
) (
  input  logic [NUM_PINS*VEC_W-1:0] vec_tbl,
  input  logic [VEC_W-1:0]          key,
  output logic                      hit,
  output logic [IDX_W-1:0]          hit_idx
);
  logic [NUM_PINS-1:0] eq;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_cmp
    assign eq[g] = (vec_tbl[g*VEC_W +: VEC_W] == key);
  end

  // Lowest matching index wins: scan from the top down
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (eq[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_evt_arb.sv
module irq_evt_arb
  import irq_req_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int IDX_W    = 5
) (
  input  logic             eoi_valid,
  input  logic             eoi_hit,
  input  logic [IDX_W-1:0] eoi_idx,
  input  logic             rewr_valid,
  input  logic [IDX_W-1:0] rewr_idx,
  input  logic             pin_valid,
  input  logic [IDX_W-1:0] pin_idx,
  output ev_kind_e         kind,
  output logic [IDX_W-1:0] sel
);
  logic rewr_ok;
  logic pin_ok;

  assign rewr_ok = (int'(rewr_idx) < NUM_PINS);
  assign pin_ok  = (int'(pin_idx) < NUM_PINS);

  always_comb begin
    kind = EV_NONE;
    sel  = '0;
    if (eoi_valid) begin
      if (eoi_hit) begin
        kind = EV_EOI;
        sel  = eoi_idx;
      end
    end else if (rewr_valid) begin
      if (rewr_ok) begin
        kind = EV_REWR;
        sel  = rewr_idx;
      end
    end else if (pin_valid) begin
      if (pin_ok) begin
        kind = EV_PIN;
        sel  = pin_idx;
      end
    end
  end
endmodule

// File: rtl/irq_svc_next.sv
module irq_svc_next
  import irq_req_pkg::*;
(
  input  ev_kind_e kind,
  input  logic     level,
  input  logic     clr_remote,
  input  logic     masked,
  input  logic     active_low,
  input  logic     level_trig,
  input  logic     req_cur,
  input  logic     rem_cur,
  output logic     req_nxt,
  output logic     rem_nxt,
  output logic     fire
);
  logic lev;
  logic svc;

  assign lev = level ^ active_low;

  always_comb begin
    req_nxt = req_cur;
    rem_nxt = rem_cur;
    fire    = 1'b0;
    svc     = 1'b0;
    unique case (kind)
      EV_EOI: begin
        rem_nxt = 1'b0;
        fire    = !masked && req_cur;
      end
      EV_REWR: begin
        if (clr_remote) rem_nxt = 1'b0;
        svc = req_cur;
      end
      EV_PIN: begin
        if (!lev) begin
          req_nxt = 1'b0;
        end else begin
          req_nxt = 1'b1;
          svc     = (!level_trig && !req_cur) || !rem_cur;
        end
      end
      default: ;
    endcase
    if (svc) begin
      if (!masked) begin
        fire = 1'b1;
        if (level_trig) rem_nxt = 1'b1;
      end
      if (!level_trig) req_nxt = 1'b0;
    end
  end
endmodule

// File: rtl/irq_req_ack.sv
module irq_req_ack
  import irq_req_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int VEC_W    = 8,
  localparam int IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pin_evt_valid,
  input  logic [IDX_W-1:0]          pin_evt_idx,
  input  logic                      pin_evt_level,
  input  logic                      eoi_valid,
  input  logic [VEC_W-1:0]          eoi_vector,
  input  logic                      rewr_valid,
  input  logic [IDX_W-1:0]          rewr_idx,
  input  logic                      rewr_clr_remote,
  input  logic [NUM_PINS-1:0]       cfg_mask,
  input  logic [NUM_PINS-1:0]       cfg_polarity,
  input  logic [NUM_PINS-1:0]       cfg_level_trig,
  input  logic [NUM_PINS*VEC_W-1:0] cfg_vector,
  output logic [NUM_PINS-1:0]       req_bits,
  output logic [NUM_PINS-1:0]       remote_bits,
  output logic                      dlv_valid,
  output logic [IDX_W-1:0]          dlv_pin
);
  logic                eoi_hit;
  logic [IDX_W-1:0]    eoi_idx;
  ev_kind_e            kind;
  logic [IDX_W-1:0]    sel;
  logic                req_nxt_b;
  logic                rem_nxt_b;
  logic                fire;

  logic [NUM_PINS-1:0] req_q, req_d;
  logic [NUM_PINS-1:0] rem_q, rem_d;
  logic                dlv_q, dlv_d;
  logic [IDX_W-1:0]    pin_q;
  logic                pin_en;

  irq_vec_search #(.NUM_PINS(NUM_PINS), .VEC_W(VEC_W), .IDX_W(IDX_W)) u_search (
    .vec_tbl (cfg_vector),
    .key     (eoi_vector),
    .hit     (eoi_hit),
    .hit_idx (eoi_idx)
  );

  irq_evt_arb #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_arb (
    .eoi_valid  (eoi_valid),
    .eoi_hit    (eoi_hit),
    .eoi_idx    (eoi_idx),
    .rewr_valid (rewr_valid),
    .rewr_idx   (rewr_idx),
    .pin_valid  (pin_evt_valid),
    .pin_idx    (pin_evt_idx),
    .kind       (kind),
    .sel        (sel)
  );

  irq_svc_next u_svc (
    .kind       (kind),
    .level      (pin_evt_level),
    .clr_remote (rewr_clr_remote),
    .masked     (cfg_mask[sel]),
    .active_low (cfg_polarity[sel]),
    .level_trig (cfg_level_trig[sel]),
    .req_cur    (req_q[sel]),
    .rem_cur    (rem_q[sel]),
    .req_nxt    (req_nxt_b),
    .rem_nxt    (rem_nxt_b),
    .fire       (fire)
  );

  // Next-state
  always_comb begin
    req_d = req_q;
    rem_d = rem_q;
    if (kind != EV_NONE) begin
      req_d[sel] = req_nxt_b;
      rem_d[sel] = rem_nxt_b;
    end
    dlv_d  = fire && (kind != EV_NONE);
    pin_en = dlv_d;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      rem_q <= '0;
      dlv_q <= 1'b0;
      pin_q <= '0;
    end else begin
      req_q <= req_d;
      rem_q <= rem_d;
      dlv_q <= dlv_d;
      if (pin_en) pin_q <= sel;
    end
  end

  assign req_bits    = req_q;
  assign remote_bits = rem_q;
  assign dlv_valid   = dlv_q;
  assign dlv_pin     = pin_q;
endmodule

// File: rtl/irq_req_ack_chk.sv
module irq_req_ack_chk #(
  parameter int NUM_PINS = 24,
  parameter int IDX_W    = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                pin_evt_valid,
  input logic [IDX_W-1:0]    pin_evt_idx,
  input logic                eoi_valid,
  input logic                rewr_valid,
  input logic [NUM_PINS-1:0] cfg_mask,
  input logic [NUM_PINS-1:0] cfg_level_trig,
  input logic [NUM_PINS-1:0] req_bits,
  input logic [NUM_PINS-1:0] remote_bits,
  input logic                dlv_valid,
  input logic [IDX_W-1:0]    dlv_pin
);
  logic [NUM_PINS-1:0] mask_q;
  logic [NUM_PINS-1:0] trig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      trig_q <= '0;
    end else begin
      mask_q <= cfg_mask;
      trig_q <= cfg_level_trig;
    end
  end

  // R4: a pulse always follows some event
  assert_fire_has_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> $past(eoi_valid || rewr_valid || pin_evt_valid));

  // R4: the delivered pin was unmasked when the event was taken
  assert_no_masked_fire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> (!mask_q[dlv_pin] && (int'(dlv_pin) < NUM_PINS)));

  // R4: a remote bit only rises on a level-mode pin
  assert_remote_level_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((remote_bits & ~$past(remote_bits) & ~trig_q) == '0));

  // R6: an end-of-interrupt never sets a remote bit
  assert_eoi_no_remote_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid |=> ((remote_bits & ~$past(remote_bits)) == '0));

  // R7: a lone out-of-range pin event leaves everything alone
  assert_range_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_evt_valid && !eoi_valid && !rewr_valid && (int'(pin_evt_idx) >= NUM_PINS))
    |=> (!dlv_valid && $stable(req_bits) && $stable(remote_bits)));

  // R9: no event in a cycle, no change
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_evt_valid && !eoi_valid && !rewr_valid)
    |=> (!dlv_valid && $stable(req_bits) && $stable(remote_bits)));
endmodule

bind irq_req_ack irq_req_ack_chk #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .pin_evt_valid  (pin_evt_valid),
  .pin_evt_idx    (pin_evt_idx),
  .eoi_valid      (eoi_valid),
  .rewr_valid     (rewr_valid),
  .cfg_mask       (cfg_mask),
  .cfg_level_trig (cfg_level_trig),
  .req_bits       (req_bits),
  .remote_bits    (remote_bits),
  .dlv_valid      (dlv_valid),
  .dlv_pin        (dlv_pin)
);

// File: tb/irq_req_ack_bench.sv
module irq_req_ack_bench;
  localparam int NP = 6;
  localparam int VW = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          pin_evt_valid, pin_evt_level;
  logic [IW-1:0] pin_evt_idx;
  logic          eoi_valid;
  logic [VW-1:0] eoi_vector;
  logic          rewr_valid, rewr_clr_remote;
  logic [IW-1:0] rewr_idx;
  logic [NP-1:0] cfg_mask, cfg_polarity, cfg_level_trig;
  logic [NP*VW-1:0] cfg_vector;
  logic [NP-1:0] req_bits, remote_bits;
  logic          dlv_valid;
  logic [IW-1:0] dlv_pin;

  // Reference model state
  logic [NP-1:0] m_req, m_rem;
  logic          m_dv;
  int            m_pin;
  int            n_chk = 0;
  int            n_bad = 0;
  bit            done = 0;

  always #10 clk = ~clk;

  irq_req_ack #(.NUM_PINS(NP), .VEC_W(VW)) u_irq_req_ack (
    .clk, .rst_n, .pin_evt_valid, .pin_evt_idx, .pin_evt_level,
    .eoi_valid, .eoi_vector, .rewr_valid, .rewr_idx, .rewr_clr_remote,
    .cfg_mask, .cfg_polarity, .cfg_level_trig, .cfg_vector,
    .req_bits, .remote_bits, .dlv_valid, .dlv_pin
  );

  task automatic serve(input int p);
    if (!cfg_mask[p]) begin
      m_dv = 1'b1; m_pin = p;
      if (cfg_level_trig[p]) m_rem[p] = 1'b1;
    end
    if (!cfg_level_trig[p]) m_req[p] = 1'b0;
  endtask

  task automatic model_step();
    int hit;
    bit lv, was;
    m_dv = 1'b0;
    if (eoi_valid) begin
      hit = -1;
      for (int i = 0; i < NP; i++)
        if (hit < 0 && cfg_vector[i*VW +: VW] == eoi_vector) hit = i;
      if (hit >= 0) begin
        m_rem[hit] = 1'b0;
        if (!cfg_mask[hit] && m_req[hit]) begin m_dv = 1'b1; m_pin = hit; end
      end
    end else if (rewr_valid) begin
      if (int'(rewr_idx) < NP) begin
        if (rewr_clr_remote) m_rem[rewr_idx] = 1'b0;
        if (m_req[rewr_idx]) serve(int'(rewr_idx));
      end
    end else if (pin_evt_valid) begin
      if (int'(pin_evt_idx) < NP) begin
        lv = pin_evt_level ^ cfg_polarity[pin_evt_idx];
        if (!lv) m_req[pin_evt_idx] = 1'b0;
        else begin
          was = m_req[pin_evt_idx];
          m_req[pin_evt_idx] = 1'b1;
          if ((!cfg_level_trig[pin_evt_idx] && !was) || !m_rem[pin_evt_idx])
            serve(int'(pin_evt_idx));
        end
      end
    end
  endtask

  task automatic check(input string tag);
    n_chk++;
    if (req_bits !== m_req) begin
      n_bad++; $display("FAIL %s req_bits actual=%b expected=%b", tag, req_bits, m_req);
    end
    n_chk++;
    if (remote_bits !== m_rem) begin
      n_bad++; $display("FAIL %s remote_bits actual=%b expected=%b", tag, remote_bits, m_rem);
    end
    n_chk++;
    if (dlv_valid !== m_dv || (m_dv && int'(dlv_pin) != m_pin)) begin
      n_bad++;
      $display("FAIL %s dlv actual=%b/%0d expected=%b/%0d", tag, dlv_valid, dlv_pin, m_dv, m_pin);
    end
  endtask

  task automatic idle_in();
    pin_evt_valid = 0; pin_evt_idx = '0; pin_evt_level = 0;
    eoi_valid = 0; eoi_vector = '0;
    rewr_valid = 0; rewr_idx = '0; rewr_clr_remote = 0;
  endtask

  // Inputs are set after a falling edge; the model advances; the next falling edge compares
  task automatic tick(input string tag);
    model_step();
    @(negedge clk);
    check(tag);
    idle_in();
  endtask

  task automatic pin(input int p, input bit lvl, input string tag);
    pin_evt_valid = 1; pin_evt_idx = IW'(p); pin_evt_level = lvl;
    tick(tag);
  endtask

  task automatic eoi(input int v, input string tag);
    eoi_valid = 1; eoi_vector = VW'(v);
    tick(tag);
  endtask

  task automatic rewr(input int p, input bit clr, input string tag);
    rewr_valid = 1; rewr_idx = IW'(p); rewr_clr_remote = clr;
    tick(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    idle_in();
    // pins 1,3,5 level; pin 2 active low; pin 4 masked; pins 3 and 5 share vector 0x33
    cfg_mask = 6'b010000; cfg_polarity = 6'b000100; cfg_level_trig = 6'b101010;
    for (int i = 0; i < NP; i++) cfg_vector[i*VW +: VW] = VW'(8'h30 + i);
    cfg_vector[5*VW +: VW] = 8'h33;
    m_req = '0; m_rem = '0; m_dv = 0; m_pin = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset state");

    pin(0, 1, "R3 R4 R5 edge pin delivers and clears");
    pin(0, 1, "R3 edge pin re-raise delivers again");
    pin(0, 0, "R2 low level on edge pin");
    pin(4, 1, "R5 masked edge pin clears without delivery");
    pin(1, 1, "R4 level pin delivers and sets remote");
    pin(1, 1, "R10 level pin held off by remote");
    eoi(8'h31, "R6 eoi redelivers pending level pin");
    pin(1, 0, "R2 level pin deassert clears request");
    pin(2, 0, "R2 active-low pin asserted by low level");
    pin(2, 1, "R2 active-low pin released by high level");
    eoi(8'h99, "R6 unmatched eoi dropped");
    pin(5, 1, "R4 shared-vector level pin delivers");
    eoi(8'h33, "R6 eoi picks lowest matching pin");
    pin(6, 1, "R7 out-of-range pin 6 ignored");
    pin(7, 1, "R7 out-of-range pin 7 ignored");
    rewr(7, 1, "R7 out-of-range rewrite ignored");
    rewr(5, 1, "R8 rewrite clears remote and reservices");
    rewr(5, 0, "R8 rewrite without clear keeps remote");
    eoi_valid = 1; eoi_vector = 8'h99;
    pin_evt_valid = 1; pin_evt_idx = 3'd0; pin_evt_level = 1;
    tick("R9 eoi outranks pin event");
    rewr_valid = 1; rewr_idx = 3'd4; rewr_clr_remote = 0;
    pin_evt_valid = 1; pin_evt_idx = 3'd3; pin_evt_level = 1;
    tick("R9 rewrite outranks pin event");
    eoi_valid = 1; eoi_vector = 8'h33;
    rewr_valid = 1; rewr_idx = 3'd5; rewr_clr_remote = 1;
    tick("R9 eoi outranks rewrite");

    for (int n = 0; n < 3000; n++) begin
      if (n % 97 == 0) begin
        cfg_mask = NP'($urandom); cfg_polarity = NP'($urandom);
        cfg_level_trig = NP'($urandom);
      end
      pin_evt_valid = ($urandom % 3) != 0;
      pin_evt_idx = IW'($urandom); pin_evt_level = 1'($urandom);
      eoi_valid = ($urandom % 5) == 0;
      eoi_vector = ($urandom % 8 == 0) ? 8'h99 : VW'(8'h30 + $urandom % 6);
      rewr_valid = ($urandom % 6) == 0;
      rewr_idx = IW'($urandom); rewr_clr_remote = 1'($urandom);
      tick("R9 random event mix");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule